// File: doc/BRIEF.md
# DMA Page Translation Table

This block translates DMA bus addresses for a single window through a table of 64-bit translation entries. An address is first aligned down to the page size. The window's bus offset is then subtracted, and the result shifted right by the page shift gives the entry index. An entry holds the translated page base in its upper bits and the access permission in its two lowest bits. The page size (as a shift), the table depth and the window's bus offset are parameters.

The block has three ports. The lookup port returns the page base, the translated base, the offset mask and the permission, registered one cycle after the request. The write port stores one entry and reports success or a parameter error. On success it also pulses a one-cycle update strobe that carries the new mapping, so a downstream translation cache can refresh. The read port returns one stored entry with the same status. Asynchronous reset and a synchronous clear input both zero the whole table, so every page faults.

Top module: `iommu_xlate_table`

## Requirements
- R1: After reset, or after a clear, every entry is zero. An in-range lookup then returns translated address 0, permission 0 and offset mask PAGE_SIZE-1.
- R2: The permission output is the low two bits of the entry: 0 means no access, 1 read-only, 2 write-only, 3 read-write.
- R3: The entry index is ((address aligned down) - BUS_OFFSET) >> PAGE_SHIFT. A lookup is in range only when this index is below DEPTH, so index DEPTH-1 hits and index DEPTH misses.
- R4: An in-range lookup returns the page base (request address with its offset bits cleared), the entry with its offset bits cleared, and the mask PAGE_SIZE-1.
- R5: An out-of-range lookup returns page base 0, translated address 0, permission 0 and an all-ones mask.
- R6: A write or read whose index is DEPTH or above reports a parameter error (err output 1) and leaves the table unchanged. A read that fails returns data 0.
- R7: A successful write stores all 64 bits of the value, including the permission bits. A later read of that page returns the stored value with err 0.
- R8: A successful write raises the update strobe for one cycle, together with its ack. The strobe carries the page base, the translated base, the mask PAGE_SIZE-1 and the permission. A failed write raises no strobe.
- R9: Every response appears exactly one cycle after its request. A lookup in the same cycle as a write to the same page sees the old entry, and a lookup in the next cycle sees the new one.
- R10: The synchronous clear takes priority over a write in the same cycle. That write is dropped with no ack and no update strobe.
- R11: The offset bits of a write or read address are ignored, so any address within a page selects that page's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous table clear |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Lookup bus address |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_iova_o | output | ADDR_W | Page base of the looked-up address |
| lk_xaddr_o | output | ADDR_W | Translated page base |
| lk_mask_o | output | ADDR_W | Offset mask |
| lk_perm_o | output | 2 | Access permission |
| wr_valid_i | input | 1 | Entry write request |
| wr_addr_i | input | ADDR_W | Write bus address |
| wr_data_i | input | ADDR_W | Entry value to store |
| wr_ack_o | output | 1 | Write status valid |
| wr_err_o | output | 1 | Write parameter error |
| rd_valid_i | input | 1 | Entry read request |
| rd_addr_i | input | ADDR_W | Read bus address |
| rd_ack_o | output | 1 | Read status valid |
| rd_err_o | output | 1 | Read parameter error |
| rd_data_o | output | ADDR_W | Entry read back |
| upd_valid_o | output | 1 | Mapping update strobe |
| upd_iova_o | output | ADDR_W | Updated page base |
| upd_xaddr_o | output | ADDR_W | Updated translated base |
| upd_mask_o | output | ADDR_W | Updated offset mask |
| upd_perm_o | output | 2 | Updated permission |

## Verification
Some properties hold on every cycle and are asserted there: the one-cycle timing of each port, the shape of a result (an aligned base with a page mask, or the all-ones no-access form), the rule that a strobe appears only with a successful ack, zero data on a failed read, and writes dropped under clear. Other behaviour depends on what the table holds, so only the bench's scenarios can show it. That covers the actual translated values and the permission codes, full 64-bit storage, the hit/miss boundary at DEPTH-1 and DEPTH, an unchanged table after rejected writes, and the old-then-new order of a lookup issued alongside a write.

// File: rtl/iommu_pkg.sv
package iommu_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_WO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic {
    ST_OK    = 1'b0,
    ST_PARAM = 1'b1
  } stat_e;

  localparam int unsigned NPORT = 3;
  localparam int unsigned P_LK  = 0;
  localparam int unsigned P_WR  = 1;
  localparam int unsigned P_RD  = 2;
endpackage

// File: rtl/iommu_index.sv
module iommu_index #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned IDX_W      = 4,
  parameter logic [ADDR_W-1:0] BUS_OFFSET = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] rel, pg;

  always_comb begin
    base_o = addr_i & ~LOW_MASK;
    rel    = base_o - BUS_OFFSET;   // below-window addresses wrap high and miss
    pg     = rel >> PAGE_SHIFT;
    hit_o  = pg < ADDR_W'(DEPTH);
    idx_o  = pg[IDX_W-1:0];
  end
endmodule

// File: rtl/iommu_store.sv
module iommu_store #(
  parameter int unsigned ENT_W = 64,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [ENT_W-1:0] lk_ent_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o
);
  logic [DEPTH-1:0][ENT_W-1:0] ent_all;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q <= '0;
      else if (clear_i)                               ent_q <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))         ent_q <= wdata_i;
    end
    assign ent_all[g] = ent_q;
  end

  assign lk_ent_o = ent_all[lk_idx_i];
  assign rd_ent_o = ent_all[rd_idx_i];
endmodule

// File: rtl/iommu_xlate_table.sv
module iommu_xlate_table
  import iommu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned DEPTH      = 16,
  parameter logic [ADDR_W-1:0] BUS_OFFSET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_valid_o,
  output logic [ADDR_W-1:0] lk_iova_o,
  output logic [ADDR_W-1:0] lk_xaddr_o,
  output logic [ADDR_W-1:0] lk_mask_o,
  output logic [1:0]        lk_perm_o,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  output logic              wr_err_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ack_o,
  output logic              rd_err_o,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic              upd_valid_o,
  output logic [ADDR_W-1:0] upd_iova_o,
  output logic [ADDR_W-1:0] upd_xaddr_o,
  output logic [ADDR_W-1:0] upd_mask_o,
  output logic [1:0]        upd_perm_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] req_addr [NPORT];
  logic [ADDR_W-1:0] req_base [NPORT];
  logic [IDX_W-1:0]  req_idx  [NPORT];
  logic              req_hit  [NPORT];

  assign req_addr[P_LK] = lk_addr_i;
  assign req_addr[P_WR] = wr_addr_i;
  assign req_addr[P_RD] = rd_addr_i;

  for (genvar k = 0; k < NPORT; k++) begin : g_idx
    iommu_index #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH),
      .IDX_W(IDX_W), .BUS_OFFSET(BUS_OFFSET)
    ) u_idx (
      .addr_i(req_addr[k]),
      .base_o(req_base[k]),
      .idx_o (req_idx[k]),
      .hit_o (req_hit[k])
    );
  end

  // clear wins over a same-cycle write
  logic wr_take, wr_ok;
  assign wr_take = wr_valid_i && !clear_i;
  assign wr_ok   = wr_take && req_hit[P_WR];

  logic [ADDR_W-1:0] lk_ent, rd_ent;

  iommu_store #(.ENT_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .we_i    (wr_ok),
    .widx_i  (req_idx[P_WR]),
    .wdata_i (wr_data_i),
    .lk_idx_i(req_idx[P_LK]),
    .lk_ent_o(lk_ent),
    .rd_idx_i(req_idx[P_RD]),
    .rd_ent_o(rd_ent)
  );

  perm_e lk_perm_d, upd_perm_d;
  stat_e wr_st_d, rd_st_d;
  assign lk_perm_d  = req_hit[P_LK] ? perm_e'(lk_ent[1:0]) : PERM_NONE;
  assign upd_perm_d = perm_e'(wr_data_i[1:0]);
  assign wr_st_d    = req_hit[P_WR] ? ST_OK : ST_PARAM;
  assign rd_st_d    = req_hit[P_RD] ? ST_OK : ST_PARAM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o  <= 1'b0;
      lk_iova_o   <= '0;
      lk_xaddr_o  <= '0;
      lk_mask_o   <= '0;
      lk_perm_o   <= '0;
      wr_ack_o    <= 1'b0;
      wr_err_o    <= 1'b0;
      rd_ack_o    <= 1'b0;
      rd_err_o    <= 1'b0;
      rd_data_o   <= '0;
      upd_valid_o <= 1'b0;
      upd_iova_o  <= '0;
      upd_xaddr_o <= '0;
      upd_mask_o  <= '0;
      upd_perm_o  <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_iova_o  <= req_hit[P_LK] ? req_base[P_LK]       : '0;
        lk_xaddr_o <= req_hit[P_LK] ? (lk_ent & ~LOW_MASK) : '0;
        lk_mask_o  <= req_hit[P_LK] ? LOW_MASK             : '1;
        lk_perm_o  <= lk_perm_d;
      end
      wr_ack_o    <= wr_take;
      wr_err_o    <= wr_take && (wr_st_d == ST_PARAM);
      upd_valid_o <= wr_ok;
      if (wr_ok) begin
        upd_iova_o  <= req_base[P_WR];
        upd_xaddr_o <= wr_data_i & ~LOW_MASK;
        upd_mask_o  <= LOW_MASK;
        upd_perm_o  <= upd_perm_d;
      end
      rd_ack_o <= rd_valid_i;
      rd_err_o <= rd_valid_i && (rd_st_d == ST_PARAM);
      if (rd_valid_i) rd_data_o <= req_hit[P_RD] ? rd_ent : '0;
    end
  end
endmodule

// File: rtl/iommu_xlate_chk.sv
module iommu_xlate_chk #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              lk_valid_i,
  input logic              wr_valid_i,
  input logic              rd_valid_i,
  input logic              lk_valid_o,
  input logic [ADDR_W-1:0] lk_iova_o,
  input logic [ADDR_W-1:0] lk_xaddr_o,
  input logic [ADDR_W-1:0] lk_mask_o,
  input logic [1:0]        lk_perm_o,
  input logic              wr_ack_o,
  input logic              wr_err_o,
  input logic              rd_ack_o,
  input logic              rd_err_o,
  input logic [ADDR_W-1:0] rd_data_o,
  input logic              upd_valid_o,
  input logic [ADDR_W-1:0] upd_xaddr_o,
  input logic [ADDR_W-1:0] upd_mask_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  a_r9_lk_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);
  a_r9_lk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o);
  a_r7_rd_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_ack_o);
  a_r6_wr_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !clear_i) |=> wr_ack_o);
  a_r5_miss_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && lk_mask_o != LOW_MASK) |->
      (lk_mask_o == '1 && lk_xaddr_o == '0 && lk_iova_o == '0 && lk_perm_o == 2'd0));
  a_r4_hit_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && lk_mask_o == LOW_MASK) |->
      ((lk_xaddr_o & LOW_MASK) == '0 && (lk_iova_o & LOW_MASK) == '0));
  a_r8_upd_needs_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (wr_ack_o && !wr_err_o));
  a_r8_upd_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_mask_o == LOW_MASK && (upd_xaddr_o & LOW_MASK) == '0));
  a_r10_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!wr_ack_o && !upd_valid_o));
  a_r6_rd_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o && rd_err_o) |-> rd_data_o == '0);
endmodule

bind iommu_xlate_table iommu_xlate_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .lk_valid_i (lk_valid_i),
  .wr_valid_i (wr_valid_i),
  .rd_valid_i (rd_valid_i),
  .lk_valid_o (lk_valid_o),
  .lk_iova_o  (lk_iova_o),
  .lk_xaddr_o (lk_xaddr_o),
  .lk_mask_o  (lk_mask_o),
  .lk_perm_o  (lk_perm_o),
  .wr_ack_o   (wr_ack_o),
  .wr_err_o   (wr_err_o),
  .rd_ack_o   (rd_ack_o),
  .rd_err_o   (rd_err_o),
  .rd_data_o  (rd_data_o),
  .upd_valid_o(upd_valid_o),
  .upd_xaddr_o(upd_xaddr_o),
  .upd_mask_o (upd_mask_o)
);

// File: tb/sim_iommu_xlate_table.sv
module sim_iommu_xlate_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int PS = 12;
  localparam int DEP = 16;
  localparam logic [AW-1:0] OFS = '0;
  localparam logic [AW-1:0] LOW = (AW'(1) << PS) - AW'(1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic lk_valid_i = 1'b0, wr_valid_i = 1'b0, rd_valid_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0, wr_addr_i = '0, wr_data_i = '0, rd_addr_i = '0;
  logic lk_valid_o, wr_ack_o, wr_err_o, rd_ack_o, rd_err_o, upd_valid_o;
  logic [AW-1:0] lk_iova_o, lk_xaddr_o, lk_mask_o, rd_data_o, upd_iova_o, upd_xaddr_o, upd_mask_o;
  logic [1:0] lk_perm_o, upd_perm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_xlate_table u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_valid_o(lk_valid_o),
    .lk_iova_o(lk_iova_o), .lk_xaddr_o(lk_xaddr_o), .lk_mask_o(lk_mask_o), .lk_perm_o(lk_perm_o),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_ack_o(wr_ack_o), .wr_err_o(wr_err_o),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_ack_o(rd_ack_o),
    .rd_err_o(rd_err_o), .rd_data_o(rd_data_o),
    .upd_valid_o(upd_valid_o), .upd_iova_o(upd_iova_o), .upd_xaddr_o(upd_xaddr_o),
    .upd_mask_o(upd_mask_o), .upd_perm_o(upd_perm_o)
  );

  typedef struct {
    logic          err;
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic [AW-1:0] c;
    logic [1:0]    p;
  } exp_t;

  exp_t  lk_q[$], wr_q[$], rd_q[$];
  string lk_t[$], wr_t[$], rd_t[$];
  logic [AW-1:0] mdl [DEP];
  int n_chk = 0, n_bad = 0;

  function automatic void chk(string tag, string fld, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, got, exp);
    end
  endfunction

  function automatic logic [AW-1:0] pg_of(logic [AW-1:0] addr);
    return ((addr & ~LOW) - OFS) >> PS;
  endfunction

  // one request cycle; model updated after expectations are formed (old data seen)
  task automatic step(bit dl, logic [AW-1:0] la, bit dw, logic [AW-1:0] wa, logic [AW-1:0] wd,
                      bit dr, logic [AW-1:0] ra, bit dc, string tag);
    exp_t e;
    logic [AW-1:0] pg;
    lk_valid_i = dl; lk_addr_i = la;
    wr_valid_i = dw; wr_addr_i = wa; wr_data_i = wd;
    rd_valid_i = dr; rd_addr_i = ra; clear_i = dc;
    if (dl) begin
      pg = pg_of(la);
      if (pg < DEP) begin
        e.err = 0; e.a = la & ~LOW; e.b = mdl[pg] & ~LOW; e.c = LOW; e.p = mdl[pg][1:0];
      end else begin
        e.err = 0; e.a = '0; e.b = '0; e.c = '1; e.p = 2'd0;
      end
      lk_q.push_back(e); lk_t.push_back(tag);
    end
    if (dr) begin
      pg = pg_of(ra);
      e.err = !(pg < DEP); e.a = (pg < DEP) ? mdl[pg] : '0; e.b = '0; e.c = '0; e.p = 2'd0;
      rd_q.push_back(e); rd_t.push_back(tag);
    end
    if (dc) begin
      for (int i = 0; i < DEP; i++) mdl[i] = '0;
    end else if (dw) begin
      pg = pg_of(wa);
      e.err = !(pg < DEP); e.a = wa & ~LOW; e.b = wd & ~LOW; e.c = LOW; e.p = wd[1:0];
      wr_q.push_back(e); wr_t.push_back(tag);
      if (pg < DEP) mdl[pg] = wd;
    end
    @(negedge clk);
    lk_valid_i = 0; wr_valid_i = 0; rd_valid_i = 0; clear_i = 0;
  endtask

  task automatic lk(logic [AW-1:0] a, string tag);
    step(1, a, 0, '0, '0, 0, '0, 0, tag);
  endtask
  task automatic wr(logic [AW-1:0] a, logic [AW-1:0] d, string tag);
    step(0, '0, 1, a, d, 0, '0, 0, tag);
  endtask
  task automatic rd(logic [AW-1:0] a, string tag);
    step(0, '0, 0, '0, '0, 1, a, 0, tag);
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_ni) begin
      if (lk_valid_o) begin
        if (lk_q.size() == 0) chk("R9", "unexpected lookup", 1, 0);
        else begin
          exp_t e; string t;
          e = lk_q.pop_front(); t = lk_t.pop_front();
          chk(t, "lk_iova", lk_iova_o, e.a);
          chk(t, "lk_xaddr", lk_xaddr_o, e.b);
          chk(t, "lk_mask", lk_mask_o, e.c);
          chk(t, "lk_perm", AW'(lk_perm_o), AW'(e.p));
        end
      end
      if (wr_ack_o) begin
        if (wr_q.size() == 0) chk("R10", "unexpected write ack", 1, 0);
        else begin
          exp_t e; string t;
          e = wr_q.pop_front(); t = wr_t.pop_front();
          chk(t, "wr_err", AW'(wr_err_o), AW'(e.err));
          chk(t, "upd_valid", AW'(upd_valid_o), AW'(!e.err));
          if (!e.err) begin
            chk(t, "upd_iova", upd_iova_o, e.a);
            chk(t, "upd_xaddr", upd_xaddr_o, e.b);
            chk(t, "upd_mask", upd_mask_o, e.c);
            chk(t, "upd_perm", AW'(upd_perm_o), AW'(e.p));
          end
        end
      end else if (upd_valid_o) chk("R8", "update without ack", 1, 0);
      if (rd_ack_o) begin
        if (rd_q.size() == 0) chk("R7", "unexpected read ack", 1, 0);
        else begin
          exp_t e; string t;
          e = rd_q.pop_front(); t = rd_t.pop_front();
          chk(t, "rd_err", AW'(rd_err_o), AW'(e.err));
          chk(t, "rd_data", rd_data_o, e.a);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEP; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset lk_valid", AW'(lk_valid_o), 0);
    chk("R1", "reset wr_ack", AW'(wr_ack_o), 0);
    chk("R1", "reset upd_valid", AW'(upd_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    lk(64'h0000_0000_0000_0000, "R1");
    lk(64'h0000_0000_0000_FFFF, "R3");      // last index, in range
    lk(64'h0000_0000_0001_0000, "R3");      // index DEPTH, miss

    wr(64'h0000_0000_0000_3ABC, 64'h1234_5678_9ABC_D003, "R11");
    lk(64'h0000_0000_0000_3123, "R4");
    wr(64'h0000_0000_0000_5000, 64'h0000_0000_A000_5001, "R8");
    wr(64'h0000_0000_0000_6FFF, 64'h0000_0000_B000_6002, "R8");
    wr(64'h0000_0000_0000_7800, 64'h0000_0000_C000_7000, "R8");
    lk(64'h0000_0000_0000_5004, "R2");
    lk(64'h0000_0000_0000_6008, "R2");
    lk(64'h0000_0000_0000_7FFC, "R2");
    rd(64'h0000_0000_0000_3FFF, "R7");
    rd(64'h0000_0000_0000_5000, "R7");

    wr(64'h0000_0000_0001_0000, 64'hDEAD_BEEF_0000_0003, "R6");
    wr(64'hFFFF_FFFF_FFFF_F000, 64'hDEAD_BEEF_0000_0003, "R6");
    rd(64'h0000_0000_0001_0000, "R6");
    lk(64'hFFFF_FFFF_FFFF_F000, "R5");
    lk(64'h0000_0000_0001_2345, "R5");
    lk(64'h0000_0000_0000_3000, "R6");      // table untouched by rejected writes
    rd(64'h0000_0000_0000_F000, "R6");

    // same-cycle write and lookup on one page, then next cycle
    step(1, 64'h9010, 1, 64'h9000, 64'h0000_0000_5555_9003, 1, 64'h9000, 0, "R9");
    lk(64'h0000_0000_0000_9010, "R9");
    rd(64'h0000_0000_0000_9000, "R9");

    // clear with a same-cycle write: write dropped
    step(0, '0, 1, 64'hA000, 64'h0000_0000_0077_A003, 0, '0, 1, "R10");
    lk(64'h0000_0000_0000_A000, "R10");
    lk(64'h0000_0000_0000_3000, "R1");
    lk(64'h0000_0000_0000_9000, "R1");
    rd(64'h0000_0000_0000_5000, "R1");

    repeat (3) @(negedge clk);
    chk("R9", "pending lookups", AW'(lk_q.size()), 0);
    chk("R10", "pending writes", AW'(wr_q.size()), 0);
    chk("R7", "pending reads", AW'(rd_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule